// File: doc/BRIEF.md
# Board I/O and Timebase Register Block

This peripheral sits on a 32-bit APB-style bus and gives software a small window (4 KB, little-endian words) onto board-level I/O and timekeeping. Software can set two user LEDs and read a set of push buttons. The buttons pass through a two-flop synchronizer and then a sampling register. The block also offers four free-running 32-bit up-counters:
- a raw system-clock cycle counter;
- a 100 Hz tick counter;
- a 1 Hz tick counter;
- a counter that advances once every PRESCALE+1 reference-clock ticks.

It also holds one general-purpose 32-bit control word. The two tick rates come from dividers whose ratios are set by the `CLK_HZ` parameter. The reference clock reaches the block as a one-cycle enable, `ref_tick`, which is synchronous to `clk`. Its nominal rate is 20 MHz.

A two-state bus tracker sequences each transfer:
- ST_IDLE moves to ST_ACCESS on a setup phase (`psel` high, `penable` low). At that edge, read data is captured into `prdata`.
- ST_ACCESS returns to ST_IDLE on the access phase (`psel` and `penable` both high). A write commits at that edge.
- ST_ACCESS also returns to ST_IDLE if `psel` drops.
- ST_ACCESS stays where it is if a new setup phase repeats.

Register byte offsets:

| Offset | Contents |
|--------|----------|
| 0x00 | LED control |
| 0x08 | Buttons |
| 0x10 | 1 Hz counter |
| 0x14 | 100 Hz counter |
| 0x18 | Cycle counter |
| 0x1C | Prescale value |
| 0x20 | Prescaled counter |
| 0x4C | Control word |

Top module: `board_io_regs`

## Requirements
- R1: After reset, `led_o` and `prdata` are 0, and the LED, prescale, control-word and all four counters read 0 apart from their advance since reset.
- R2: A write to offset 0x00 stores only bits [1:0], which drive `led_o[1:0]` from the cycle after the access edge; reads of 0x00 return those bits with bits [31:2] zero.
- R3: Offsets 0x1C (prescale) and 0x4C (control word) hold all 32 written bits and read back the last value written.
- R4: Offset 0x08 returns the `btn_i` level as it stood three clock edges earlier, zero-extended; writes to 0x08 change nothing.
- R5: The cycle counter at 0x18 increases by one on every clock edge after reset; a read returns the count of edges before the setup-phase edge.
- R6: The 100 Hz counter (0x14) reads floor(n/(CLK_HZ/100)) and the 1 Hz counter (0x10) reads floor(n/CLK_HZ), where n is the cycle counter value.
- R7: The prescaled counter (0x20) advances once per PRESCALE+1 `ref_tick` pulses; any write to 0x1C restarts the divide count at zero.
- R8: Writes to 0x10, 0x14, 0x18 and 0x20 are ignored; the counters keep their own sequence.
- R9: Reads from any offset not listed return 0, and writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| ref_tick | input | 1 | One-cycle reference clock enable |
| btn_i | input | NBTN | Raw push-button levels |
| led_o | output | 2 | LED drive |

## Verification
The hardest case to reach from the ports is the restart of the prescaler's hidden divide phase. A restart in the middle of a period looks exactly like no restart unless the ref_tick pulses before and after the write are counted precisely. The stimulus therefore gives two pulses with prescale 2. It then rewrites the same value and shows that two further pulses leave the counter unchanged, while a third pulse advances it. The 1 Hz counter needs the divider scaled down through `CLK_HZ` and a wait of over two thousand cycles.

// File: rtl/bio_pkg.sv
`timescale 1ns/1ps
package bio_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } bus_st_e;

    localparam logic [11:0] OFS_LAMP  = 12'h000;
    localparam logic [11:0] OFS_KEYS  = 12'h008;
    localparam logic [11:0] OFS_SEC   = 12'h010;
    localparam logic [11:0] OFS_CENTI = 12'h014;
    localparam logic [11:0] OFS_CYC   = 12'h018;
    localparam logic [11:0] OFS_DIVV  = 12'h01C;
    localparam logic [11:0] OFS_DCNT  = 12'h020;
    localparam logic [11:0] OFS_CTRL  = 12'h04C;
endpackage

// File: rtl/bio_sync.sv
`timescale 1ns/1ps
module bio_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/bio_tick_div.sv
`timescale 1ns/1ps
module bio_tick_div #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse_o
);
    localparam int CW = $clog2((DIV > 1) ? DIV : 2);

    logic [CW-1:0] cnt_q;

    assign pulse_o = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (pulse_o) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_chk
            // R6: an enable pulse never lasts two cycles when dividing
            p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_o |=> !pulse_o);
        end
    endgenerate
endmodule

// File: rtl/bio_prescaler.sv
`timescale 1ns/1ps
module bio_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_tick_i,
    input  logic         restart_i,
    input  logic [W-1:0] limit_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;

    assign tick_o = ref_tick_i && !restart_i && (cnt_q == limit_i);

    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (ref_tick_i)
            cnt_q <= (cnt_q == limit_i) ? '0 : cnt_q + 1'b1;
    end

    // R7: a write to the divide value restarts the phase
    p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/board_io_regs.sv
`timescale 1ns/1ps
module board_io_regs #(
    parameter int CLK_HZ = 250_000_000,
    parameter int NBTN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [11:0]     paddr,
    input  logic [31:0]     pwdata,
    output logic [31:0]     prdata,
    input  logic            ref_tick,
    input  logic [NBTN-1:0] btn_i,
    output logic [1:0]      led_o
);
    import bio_pkg::*;

    localparam int DIV_SEC   = CLK_HZ;
    localparam int DIV_CENTI = CLK_HZ / 100;

    bus_st_e state_q, state_d;

    logic [1:0]      lamp_q;
    logic [31:0]     divv_q, ctrl_q;
    logic [31:0]     sec_q, centi_q, cyc_q, dcnt_q;
    logic [NBTN-1:0] keys_sync, keys_q;
    logic            sec_en, centi_en, dcnt_en;
    logic            setup_hit, wr_do, mapped;
    logic [31:0]     rd_mux;

    bio_sync #(.W(NBTN)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(keys_sync));

    bio_tick_div #(.DIV(DIV_SEC)) u_div_sec (
        .clk(clk), .rst_n(rst_n), .pulse_o(sec_en));

    bio_tick_div #(.DIV(DIV_CENTI)) u_div_centi (
        .clk(clk), .rst_n(rst_n), .pulse_o(centi_en));

    bio_prescaler #(.W(32)) u_presc (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
        .restart_i(wr_do && (paddr == OFS_DIVV)),
        .limit_i(divv_q), .tick_o(dcnt_en));

    assign setup_hit = psel && !penable;
    assign wr_do     = (state_q == ST_ACCESS) && psel && penable && pwrite;
    assign mapped    = paddr inside {OFS_LAMP, OFS_KEYS, OFS_SEC, OFS_CENTI,
                                     OFS_CYC, OFS_DIVV, OFS_DCNT, OFS_CTRL};
    assign led_o     = lamp_q;

    // bus phase tracker: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (setup_hit) state_d = ST_ACCESS;
            ST_ACCESS: if (!psel || penable) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (paddr)
            OFS_LAMP:  rd_mux = {30'd0, lamp_q};
            OFS_KEYS:  rd_mux = 32'(keys_q);
            OFS_SEC:   rd_mux = sec_q;
            OFS_CENTI: rd_mux = centi_q;
            OFS_CYC:   rd_mux = cyc_q;
            OFS_DIVV:  rd_mux = divv_q;
            OFS_DCNT:  rd_mux = dcnt_q;
            OFS_CTRL:  rd_mux = ctrl_q;
            default:   rd_mux = 32'd0;
        endcase
    end

    // output process: read data captured at the setup edge
    always_ff @(posedge clk) begin
        if (!rst_n)                   prdata <= 32'd0;
        else if (setup_hit && !pwrite) prdata <= rd_mux;
    end

    // writable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lamp_q <= 2'd0;
            divv_q <= 32'd0;
            ctrl_q <= 32'd0;
        end else if (wr_do) begin
            if (paddr == OFS_LAMP) lamp_q <= pwdata[1:0];
            if (paddr == OFS_DIVV) divv_q <= pwdata;
            if (paddr == OFS_CTRL) ctrl_q <= pwdata;
        end
    end

    // counters and button sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= 32'd0;
            centi_q <= 32'd0;
            cyc_q   <= 32'd0;
            dcnt_q  <= 32'd0;
            keys_q  <= '0;
        end else begin
            cyc_q  <= cyc_q + 32'd1;
            keys_q <= keys_sync;
            if (sec_en)   sec_q   <= sec_q + 32'd1;
            if (centi_en) centi_q <= centi_q + 32'd1;
            if (dcnt_en)  dcnt_q  <= dcnt_q + 32'd1;
        end
    end

    // R2: committed LED write appears on the pins next cycle
    p_led_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_do && paddr == OFS_LAMP) |=> (led_o == $past(pwdata[1:0])));

    // R3: control word holds unless written there
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_do && paddr == OFS_CTRL) |=> $stable(ctrl_q));

    // R5, R8: cycle counter steps by one regardless of bus writes
    p_cyc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cyc_q == $past(cyc_q) + 32'd1));

    // R9: read setup at an unmapped offset yields zero data
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_hit && !pwrite && !mapped) |=> (prdata == 32'd0));
endmodule

// File: tb/sim_board_io_regs.sv
`timescale 1ns/1ps
module sim_board_io_regs;
    localparam int CLK_HZ = 1000;
    localparam int NBTN   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0]     paddr = '0;
    logic [31:0]     pwdata = '0;
    logic [31:0]     prdata;
    logic            ref_tick = 1'b0;
    logic [NBTN-1:0] btn_i = '0;
    logic [1:0]      led_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int unsigned bench_cyc = 0;
    logic [1:0]  m_lamp = '0;
    logic [31:0] m_divv = '0, m_ctrl = '0, m_dcnt = '0;
    int unsigned m_phase = 0;
    logic [NBTN-1:0] m_keys = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    board_io_regs #(.CLK_HZ(CLK_HZ), .NBTN(NBTN)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .ref_tick(ref_tick), .btn_i(btn_i), .led_o(led_o));

    always @(posedge clk) begin
        if (!rst_n) bench_cyc <= 0;
        else        bench_cyc <= bench_cyc + 1;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_val(input logic [11:0] a);
        case (a)
            12'h000: return {30'd0, m_lamp};
            12'h008: return 32'(m_keys);
            12'h010: return bench_cyc / CLK_HZ;
            12'h014: return bench_cyc / (CLK_HZ / 100);
            12'h018: return bench_cyc;
            12'h01C: return m_divv;
            12'h020: return m_dcnt;
            12'h04C: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    // driver: write
    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        case (a)
            12'h000: m_lamp = d[1:0];
            12'h01C: begin m_divv = d; m_phase = 0; end
            12'h04C: m_ctrl = d;
            default: ;
        endcase
    endtask

    // driver: read, pushes the expected item into the scoreboard
    task automatic apb_rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        exp_q.push_back(model_val(a));
        tag_q.push_back(tag);
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic ref_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1;
            @(negedge clk); ref_tick = 0;
            m_phase++;
            if (m_phase == m_divv + 1) begin
                m_phase = 0;
                m_dcnt++;
            end
        end
    endtask

    task automatic set_keys(input logic [NBTN-1:0] v);
        @(negedge clk); btn_i = v;
        repeat (4) @(negedge clk);
        m_keys = v;
    endtask

    // monitor: compares read data in the access phase
    always @(posedge clk) begin
        #1;
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                check(0, "unexpected read", prdata, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(prdata === e, t, prdata, e);
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(led_o === 2'd0, "R1 led_o after reset", 32'(led_o), 0);
        check(prdata === 32'd0, "R1 prdata after reset", prdata, 0);
        apb_rd(12'h000, "R1 lamp reset");
        apb_rd(12'h01C, "R1 divide reset");
        apb_rd(12'h04C, "R1 ctrl reset");
        apb_rd(12'h020, "R1 prescaled reset");
        apb_rd(12'h018, "R5 cycle after reset");

        // R2
        apb_wr(12'h000, 32'hFFFF_FFFE);
        check(led_o === 2'b10, "R2 led_o after write", 32'(led_o), 2);
        apb_rd(12'h000, "R2 lamp readback upper zero");
        apb_wr(12'h000, 32'h0000_0001);
        check(led_o === 2'b01, "R2 led_o second write", 32'(led_o), 1);

        // R3
        apb_wr(12'h01C, 32'hA5A5_5A5A);
        apb_rd(12'h01C, "R3 divide value");
        apb_wr(12'h04C, 32'hDEAD_BEEF);
        apb_rd(12'h04C, "R3 ctrl first");
        apb_wr(12'h04C, 32'h1234_5678);
        apb_rd(12'h04C, "R3 ctrl second");

        // R4
        set_keys(2'b10);
        apb_rd(12'h008, "R4 keys 10");
        apb_wr(12'h008, 32'hFFFF_FFFF);
        apb_rd(12'h008, "R4 keys after write");
        check(led_o === 2'b01, "R4 led_o untouched", 32'(led_o), 1);
        set_keys(2'b01);
        apb_rd(12'h008, "R4 keys 01");

        // R5, R6
        apb_rd(12'h018, "R5 cycle a");
        repeat (37) @(negedge clk);
        apb_rd(12'h018, "R5 cycle b");
        apb_rd(12'h014, "R6 100Hz a");
        repeat (23) @(negedge clk);
        apb_rd(12'h014, "R6 100Hz b");
        repeat (2100) @(negedge clk);
        apb_rd(12'h010, "R6 1Hz");
        apb_rd(12'h014, "R6 100Hz c");

        // R7
        apb_wr(12'h01C, 32'd2);
        ref_pulse(7);
        apb_rd(12'h020, "R7 prescaled divide 3");
        ref_pulse(1);
        apb_wr(12'h01C, 32'd2);
        ref_pulse(2);
        apb_rd(12'h020, "R7 restart holds count");
        ref_pulse(1);
        apb_rd(12'h020, "R7 after restart period");
        apb_wr(12'h01C, 32'd0);
        ref_pulse(3);
        apb_rd(12'h020, "R7 divide 1");

        // R8
        apb_wr(12'h018, 32'd0);
        apb_rd(12'h018, "R8 cycle ignores write");
        apb_wr(12'h014, 32'hFFFF_0000);
        apb_rd(12'h014, "R8 100Hz ignores write");
        apb_wr(12'h010, 32'h0000_00FF);
        apb_rd(12'h010, "R8 1Hz ignores write");
        apb_wr(12'h020, 32'h0000_1000);
        apb_rd(12'h020, "R8 prescaled ignores write");

        // R9
        apb_wr(12'h030, 32'hCAFE_F00D);
        apb_rd(12'h030, "R9 unmapped read");
        apb_rd(12'hFFC, "R9 top of window");
        apb_wr(12'h004, 32'h0000_0003);
        apb_rd(12'h000, "R9 lamp unchanged");
        apb_rd(12'h04C, "R9 ctrl unchanged");
        check(led_o === 2'b01, "R9 led_o unchanged", 32'(led_o), 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule